// File: doc/BRIEF.md
# GPIO-Triggered Keyboard Scan-Code Sequencer

The sequencer watches a set of general-purpose event inputs and turns each one into a keyboard byte stream. When a channel's input rises, the block emits that channel's make code. Depending on the channel's control register, left Ctrl, left Alt, left Shift and an extended-key prefix are sent ahead of it. While the input stays high, the make code repeats on its own: first after a programmable start delay, then at a programmable interval. When the input falls, the block sends the key's break code, followed by break codes for the modifiers that were pressed.

Bytes leave one at a time on a valid/ready interface. Each channel has a control register and a make-code register, both reached through an index/data port. Timing is counted from a 1 kHz tick input, so the delay and interval values are in milliseconds. Only one channel owns the output at a time. Any other channel that fires meanwhile waits in a pending set and is served lowest-numbered first.

Top module: `gpio_keyseq`

## Requirements
- R1: After reset, `key_valid` is 0 and every control register and make-code register reads back 0.
- R2: The control register of channel n sits at index B8h+n and its make-code register at BCh+n. A write takes effect when `reg_we` is high. `reg_rdata` shows the register named by `reg_index` one clock edge later. Any other index reads 0 and ignores writes.
- R3: An event is a rising edge of a `gpio_in` bit after a two-flop synchronizer. When the block is idle, `key_valid` rises on the 4th clock edge after the input changes.
- R4: The press stream is emitted in a fixed order, and disabled items are left out. The order is 14h if control bit 7 is set, 11h if bit 6 is set, 12h if bit 5 is set, E0h if bit 4 is set, and then the make code.
- R5: When the synchronized input falls, the release stream is sent. It starts with E0h (only if bit 4 is set), F0h and the make code. It continues with F0h 12h (bit 5), F0h 11h (bit 6) and F0h 14h (bit 7). An input that falls before the press stream ends is released right after the press stream.
- R6: A byte is consumed only on a clock edge where `key_valid` and `key_ready` are both high. While `key_ready` is low, `key_valid` and `key_byte` hold.
- R7: While the input stays high after the press stream, the first repeat is due after (d+1)*250 ticks, where d is control bits 3:2. One tick fewer produces no repeat.
- R8: Later repeats come every 33, 67, 100 or 200 ticks for control bits 1:0 = 00, 01, 10, 11. Each repeat is the make code byte alone, with no modifier or E0h prefix.
- R9: When several channels are pending, the lowest-numbered channel is served first. A channel that fires while another is active waits until that channel's release stream has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1khz | input | 1 | One-cycle pulse per millisecond |
| gpio_in | input | 4 | Asynchronous event inputs, one per channel |
| reg_index | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write enable |
| reg_rdata | output | 8 | Registered read data |
| key_byte | output | 8 | Scan-code byte |
| key_valid | output | 1 | `key_byte` is valid |
| key_ready | input | 1 | Consumer accepts the byte |

## Verification
From idle, `key_valid` is due on the fourth edge after a `gpio_in` change, and read data one edge after the index. The bench checks both by counting edges and sampling at the falling edge that follows. A repeat byte appears on the edge that counts the expiring tick. Ticks are therefore spaced four cycles apart and sent only once the press stream has been drained, and the byte count is checked a few cycles after the boundary tick and after the tick just before it. Whole streams are collected under random back-pressure. They are compared only after the expected length has arrived plus a settling gap, so a dropped or duplicated byte shows up as a mismatch.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;

  typedef enum logic [2:0] {PH_IDLE, PH_PRESS, PH_HOLD, PH_REP, PH_REL} phase_e;

  typedef struct packed {
    logic       ctrl;
    logic       alt;
    logic       shift;
    logic       pre;
    logic [1:0] dly;
    logic [1:0] rep;
  } cfg_t;

  localparam logic [7:0] KC_CTRL  = 8'h14;
  localparam logic [7:0] KC_ALT   = 8'h11;
  localparam logic [7:0] KC_SHIFT = 8'h12;
  localparam logic [7:0] KC_EXT   = 8'hE0;
  localparam logic [7:0] KC_BRK   = 8'hF0;

  // step numbering: press 0..4, release 5..13, repeat 14
  localparam int ST_PRESS_LO = 0;
  localparam int ST_PRESS_HI = 4;
  localparam int ST_REL_LO   = 5;
  localparam int ST_REL_HI   = 13;
  localparam int ST_REP      = 14;

  function automatic logic [7:0] step_byte(input logic [3:0] st, input logic [7:0] mk);
    case (st)
      4'd0:  return KC_CTRL;
      4'd1:  return KC_ALT;
      4'd2:  return KC_SHIFT;
      4'd3:  return KC_EXT;
      4'd5:  return KC_EXT;
      4'd6:  return KC_BRK;
      4'd8:  return KC_BRK;
      4'd9:  return KC_SHIFT;
      4'd10: return KC_BRK;
      4'd11: return KC_ALT;
      4'd12: return KC_BRK;
      4'd13: return KC_CTRL;
      default: return mk;
    endcase
  endfunction

  function automatic logic step_en(input logic [3:0] st, input cfg_t c);
    case (st)
      4'd0, 4'd12, 4'd13: return c.ctrl;
      4'd1, 4'd10, 4'd11: return c.alt;
      4'd2, 4'd8, 4'd9:   return c.shift;
      4'd3, 4'd5:         return c.pre;
      default:            return 1'b1;
    endcase
  endfunction

  // returns {found, step}: first enabled step in [lo, hi]
  function automatic logic [4:0] find_step(input int lo, input int hi, input cfg_t c);
    logic       f;
    logic [3:0] s;
    f = 1'b0;
    s = 4'd0;
    for (int i = 0; i < 15; i++) begin
      if (!f && i >= lo && i <= hi && step_en(4'(i), c)) begin
        f = 1'b1;
        s = 4'(i);
      end
    end
    return {f, s};
  endfunction

  function automatic int delay_ticks(input logic [1:0] d);
    return (int'(d) + 1) * 250;
  endfunction

  function automatic int rate_ticks(input logic [1:0] r);
    case (r)
      2'd0:    return 33;
      2'd1:    return 67;
      2'd2:    return 100;
      default: return 200;
    endcase
  endfunction

endpackage

// File: rtl/keyseq_events.sv
module keyseq_events #(
  parameter int NCH  = 4,
  parameter int SYNC = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] gpio_in,
  input  logic [NCH-1:0] take,
  output logic [NCH-1:0] level,
  output logic [NCH-1:0] pending
);
  logic [NCH-1:0] sync_r [SYNC];
  logic [NCH-1:0] prev_r;
  logic [NCH-1:0] rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC; i++) sync_r[i] <= '0;
    end else begin
      sync_r[0] <= gpio_in;
      for (int i = 1; i < SYNC; i++) sync_r[i] <= sync_r[i-1];
    end
  end

  assign level = sync_r[SYNC-1];
  assign rise  = level & ~prev_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_r  <= '0;
      pending <= '0;
    end else begin
      prev_r  <= level;
      pending <= (pending & ~take) | rise;
    end
  end
endmodule

// File: rtl/keyseq_regs.sv
module keyseq_regs
  import keyseq_pkg::*;
#(
  parameter int               NCH       = 4,
  parameter int               IDX_W     = 8,
  parameter logic [IDX_W-1:0] CTRL_BASE = 8'hB8,
  parameter logic [IDX_W-1:0] MAKE_BASE = 8'hBC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] reg_index,
  input  logic [7:0]       reg_wdata,
  input  logic             reg_we,
  output logic [7:0]       reg_rdata,
  output cfg_t             cfg_o  [NCH],
  output logic [7:0]       make_o [NCH]
);
  localparam int CW      = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CTRL_LO = int'(CTRL_BASE);
  localparam int MAKE_LO = int'(MAKE_BASE);

  logic [7:0]    ctrl_r [NCH];
  logic [7:0]    make_r [NCH];
  logic          ctrl_hit, make_hit;
  logic [CW-1:0] csel, msel;

  always_comb begin
    int idx;
    idx      = int'(reg_index);
    ctrl_hit = (idx >= CTRL_LO) && (idx < CTRL_LO + NCH);
    make_hit = (idx >= MAKE_LO) && (idx < MAKE_LO + NCH);
    csel     = CW'(idx - CTRL_LO);
    msel     = CW'(idx - MAKE_LO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        ctrl_r[i] <= '0;
        make_r[i] <= '0;
      end
    end else if (reg_we) begin
      if (ctrl_hit) ctrl_r[csel] <= reg_wdata;
      if (make_hit) make_r[msel] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           reg_rdata <= '0;
    else if (ctrl_hit) reg_rdata <= ctrl_r[csel];
    else if (make_hit) reg_rdata <= make_r[msel];
    else               reg_rdata <= '0;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign cfg_o[g]  = cfg_t'(ctrl_r[g]);
    assign make_o[g] = make_r[g];
  end
endmodule

// File: rtl/keyseq_timer.sv
module keyseq_timer
  import keyseq_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       tick,
  input  logic       first,
  input  logic [1:0] dly_sel,
  input  logic [1:0] rep_sel,
  output logic       expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit  = first ? CNT_W'(delay_ticks(dly_sel)) : CNT_W'(rate_ticks(rep_sel));
  assign expire = active && tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else if (tick)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/keyseq_engine.sv
module keyseq_engine
  import keyseq_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pending,
  input  logic [NCH-1:0] level,
  input  cfg_t           cfg_i  [NCH],
  input  logic [7:0]     make_i [NCH],
  input  logic           expire,
  input  logic           out_ready,
  output logic [NCH-1:0] take,
  output phase_e         phase,
  output logic [CW-1:0]  chan,
  output cfg_t           cfg_q,
  output logic [7:0]     make_q,
  output logic           first,
  output logic           out_valid,
  output logic [7:0]     out_byte
);
  logic [3:0]    step;
  logic          any_pend;
  logic [CW-1:0] sel;
  logic [4:0]    nxt, press_first, rel_first;
  int            last;

  always_comb begin
    any_pend = 1'b0;
    sel      = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pending[i]) begin
        any_pend = 1'b1;
        sel      = CW'(i);
      end
    end
  end

  always_comb begin
    take = '0;
    if (phase == PH_IDLE && any_pend) take[sel] = 1'b1;
  end

  always_comb begin
    case (phase)
      PH_PRESS: last = ST_PRESS_HI;
      PH_REL:   last = ST_REL_HI;
      default:  last = 0;
    endcase
    nxt         = find_step(int'(step) + 1, last, cfg_q);
    press_first = find_step(ST_PRESS_LO, ST_PRESS_HI, cfg_i[sel]);
    rel_first   = find_step(ST_REL_LO, ST_REL_HI, cfg_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      step      <= '0;
      chan      <= '0;
      cfg_q     <= '0;
      make_q    <= '0;
      first     <= 1'b0;
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (any_pend) begin
            chan      <= sel;
            cfg_q     <= cfg_i[sel];
            make_q    <= make_i[sel];
            step      <= press_first[3:0];
            out_byte  <= step_byte(press_first[3:0], make_i[sel]);
            out_valid <= 1'b1;
            phase     <= PH_PRESS;
          end
        end
        PH_HOLD: begin
          if (!level[chan]) begin
            step      <= rel_first[3:0];
            out_byte  <= step_byte(rel_first[3:0], make_q);
            out_valid <= 1'b1;
            phase     <= PH_REL;
          end else if (expire) begin
            step      <= 4'(ST_REP);
            out_byte  <= make_q;
            out_valid <= 1'b1;
            phase     <= PH_REP;
          end
        end
        default: begin
          if (out_valid && out_ready) begin
            if (nxt[4]) begin
              step     <= nxt[3:0];
              out_byte <= step_byte(nxt[3:0], make_q);
            end else begin
              out_valid <= 1'b0;
              case (phase)
                PH_PRESS: begin phase <= PH_HOLD; first <= 1'b1; end
                PH_REP:   begin phase <= PH_HOLD; first <= 1'b0; end
                default:  phase <= PH_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/gpio_keyseq.sv
module gpio_keyseq
  import keyseq_pkg::*;
#(
  parameter int         NCH       = 4,
  parameter int         SYNC      = 2,
  parameter int         CNT_W     = 10,
  parameter logic [7:0] CTRL_BASE = 8'hB8,
  parameter logic [7:0] MAKE_BASE = 8'hBC
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick_1khz,
  input  logic [NCH-1:0] gpio_in,
  input  logic [7:0]     reg_index,
  input  logic [7:0]     reg_wdata,
  input  logic           reg_we,
  output logic [7:0]     reg_rdata,
  output logic [7:0]     key_byte,
  output logic           key_valid,
  input  logic           key_ready
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] level, pending, take;
  cfg_t           cfg_a  [NCH];
  logic [7:0]     make_a [NCH];
  phase_e         phase;
  logic [CW-1:0]  chan;
  cfg_t           cfg_q;
  logic [7:0]     make_q;
  logic           first, expire;

  keyseq_events #(.NCH(NCH), .SYNC(SYNC)) u_events (
    .clk(clk), .rst(rst), .gpio_in(gpio_in), .take(take),
    .level(level), .pending(pending)
  );

  keyseq_regs #(.NCH(NCH), .IDX_W(8), .CTRL_BASE(CTRL_BASE), .MAKE_BASE(MAKE_BASE)) u_regs (
    .clk(clk), .rst(rst), .reg_index(reg_index), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .cfg_o(cfg_a), .make_o(make_a)
  );

  keyseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .active(phase == PH_HOLD), .tick(tick_1khz),
    .first(first), .dly_sel(cfg_q.dly), .rep_sel(cfg_q.rep), .expire(expire)
  );

  keyseq_engine #(.NCH(NCH)) u_engine (
    .clk(clk), .rst(rst), .pending(pending), .level(level),
    .cfg_i(cfg_a), .make_i(make_a), .expire(expire), .out_ready(key_ready),
    .take(take), .phase(phase), .chan(chan), .cfg_q(cfg_q), .make_q(make_q),
    .first(first), .out_valid(key_valid), .out_byte(key_byte)
  );
endmodule

// File: rtl/gpio_keyseq_chk.sv
module gpio_keyseq_chk
  import keyseq_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic           key_valid,
  input logic           key_ready,
  input logic [7:0]     key_byte,
  input phase_e         phase,
  input logic [CW-1:0]  chan,
  input logic [7:0]     make_q,
  input logic [NCH-1:0] pending
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!key_valid && phase == PH_IDLE));

  // R6
  hold_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (key_valid && !key_ready) |=> (key_valid && $stable(key_byte)));

  // R9
  chan_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> (phase == PH_IDLE || $stable(chan)));

  // R8
  rep_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_REP && key_valid) |-> (key_byte == make_q));

  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && pending == '0) |=> !key_valid);
endmodule

bind gpio_keyseq gpio_keyseq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .key_valid(key_valid), .key_ready(key_ready),
  .key_byte(key_byte), .phase(phase), .chan(chan), .make_q(make_q),
  .pending(pending)
);

// File: tb/gpio_keyseq_test.sv
module gpio_keyseq_test;
  logic       clk = 0;
  logic       rst = 1;
  logic       tick_1khz = 0;
  logic [3:0] gpio_in = '0;
  logic [7:0] reg_index = '0, reg_wdata = '0;
  logic       reg_we = 0;
  logic [7:0] reg_rdata, key_byte;
  logic       key_valid;
  logic       key_ready;
  bit         force_ready = 0;
  int         total = 0, bad = 0;
  bit [7:0]   got[$];
  bit [7:0]   expq[$];

  always #10 clk = ~clk;

  gpio_keyseq uut (
    .clk(clk), .rst(rst), .tick_1khz(tick_1khz), .gpio_in(gpio_in),
    .reg_index(reg_index), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .key_byte(key_byte), .key_valid(key_valid),
    .key_ready(key_ready)
  );

  // consumer: choose ready, then record the byte that the next edge takes
  always @(negedge clk) begin
    if (rst) key_ready = 1'b0;
    else begin
      key_ready = force_ready ? 1'b1 : (($urandom % 4) != 0);
      if (key_valid && key_ready) got.push_back(key_byte);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk); reg_index = idx; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
    @(negedge clk); reg_index = idx;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1khz = 1;
      @(negedge clk); tick_1khz = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic wait_bytes(input int n);
    for (int i = 0; i < 3000 && got.size() < n; i++) @(negedge clk);
  endtask

  // expected streams built from the requirements
  task automatic add_press(input logic [7:0] c, input logic [7:0] mk);
    if (c[7]) expq.push_back(8'h14);
    if (c[6]) expq.push_back(8'h11);
    if (c[5]) expq.push_back(8'h12);
    if (c[4]) expq.push_back(8'hE0);
    expq.push_back(mk);
  endtask

  task automatic add_release(input logic [7:0] c, input logic [7:0] mk);
    if (c[4]) expq.push_back(8'hE0);
    expq.push_back(8'hF0); expq.push_back(mk);
    if (c[5]) begin expq.push_back(8'hF0); expq.push_back(8'h12); end
    if (c[6]) begin expq.push_back(8'hF0); expq.push_back(8'h11); end
    if (c[7]) begin expq.push_back(8'hF0); expq.push_back(8'h14); end
  endtask

  function automatic int press_len(input logic [7:0] c);
    return 1 + int'(c[7]) + int'(c[6]) + int'(c[5]) + int'(c[4]);
  endfunction

  function automatic int exp_delay(input logic [1:0] d);
    return (int'(d) + 1) * 250;
  endfunction

  function automatic int exp_rate(input logic [1:0] r);
    case (r)
      2'd0: return 33;
      2'd1: return 67;
      2'd2: return 100;
      default: return 200;
    endcase
  endfunction

  task automatic compare_stream(input string req);
    int bad_i;
    wait_bytes(expq.size());
    repeat (30) @(negedge clk);
    bad_i = -1;
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      if (bad_i < 0 && got[i] != expq[i]) bad_i = i;
    if (got.size() != expq.size())
      chk(0, req, "stream length", got.size(), expq.size());
    else if (bad_i >= 0)
      chk(0, req, $sformatf("byte %0d", bad_i), got[bad_i], expq[bad_i]);
    else
      chk(1, req, "stream", 0, 0);
    got.delete();
    expq.delete();
  endtask

  task automatic setup_ch(input int ch, input logic [7:0] c, input logic [7:0] mk);
    reg_write(8'hB8 + 8'(ch), c);
    reg_write(8'hBC + 8'(ch), mk);
  endtask

  task automatic typematic_case(input int ch, input logic [7:0] c, input logic [7:0] mk);
    int pl;
    pl = press_len(c);
    force_ready = 1;
    setup_ch(ch, c, mk);
    @(negedge clk); gpio_in[ch] = 1;
    wait_bytes(pl);
    repeat (10) @(negedge clk);
    pulse_ticks(exp_delay(c[3:2]) - 1); repeat (5) @(negedge clk);
    chk(got.size() == pl, "R7", "no repeat one tick early", got.size(), pl);
    pulse_ticks(1); repeat (5) @(negedge clk);
    chk(got.size() == pl + 1, "R7", "first repeat at delay", got.size(), pl + 1);
    pulse_ticks(exp_rate(c[1:0]) - 1); repeat (5) @(negedge clk);
    chk(got.size() == pl + 1, "R8", "no repeat before interval", got.size(), pl + 1);
    pulse_ticks(1); repeat (5) @(negedge clk);
    chk(got.size() == pl + 2, "R8", "second repeat at interval", got.size(), pl + 2);
    @(negedge clk); gpio_in[ch] = 0;
    add_press(c, mk); expq.push_back(mk); expq.push_back(mk); add_release(c, mk);
    compare_stream("R8 R5 repeat is bare make byte");
    force_ready = 0;
  endtask

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk(key_valid == 0, "R1", "key_valid after reset", key_valid, 0);
    for (int ch = 0; ch < 4; ch++) begin
      reg_read(8'hB8 + 8'(ch), rd);
      chk(rd == 0, "R1", "ctrl reset", rd, 0);
      reg_read(8'hBC + 8'(ch), rd);
      chk(rd == 0, "R1", "make reset", rd, 0);
    end

    // R2 register access
    reg_write(8'hB9, 8'hA5);
    reg_read(8'hB9, rd); chk(rd == 8'hA5, "R2", "ctrl readback", rd, 8'hA5);
    reg_write(8'hBD, 8'h1C);
    reg_read(8'hBD, rd); chk(rd == 8'h1C, "R2", "make readback", rd, 8'h1C);
    reg_write(8'hC0, 8'hFF);
    reg_read(8'hC0, rd); chk(rd == 0, "R2", "unmapped read", rd, 0);
    reg_write(8'hB7, 8'h77);
    reg_read(8'hB7, rd); chk(rd == 0, "R2", "unmapped below", rd, 0);
    reg_read(8'hB8, rd); chk(rd == 0, "R2", "neighbour untouched", rd, 0);
    reg_write(8'hB9, 8'h00);

    // R3 latency from idle
    force_ready = 1;
    setup_ch(0, 8'h00, 8'h1C);
    @(negedge clk); gpio_in[0] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(key_valid == 0, "R3", "valid before 4th edge", key_valid, 0);
    @(negedge clk);
    chk(key_valid == 1, "R3", "valid on 4th edge", key_valid, 1);
    repeat (10) @(negedge clk);
    gpio_in[0] = 0;
    expq.push_back(8'h1C); expq.push_back(8'hF0); expq.push_back(8'h1C);
    compare_stream("R4 R5 plain key");
    force_ready = 0;

    // R4 R5 all prefixes, random back-pressure (R6)
    setup_ch(2, 8'hF0, 8'h2B);
    @(negedge clk); gpio_in[2] = 1;
    wait_bytes(5); repeat (5) @(negedge clk);
    gpio_in[2] = 0;
    add_press(8'hF0, 8'h2B); add_release(8'hF0, 8'h2B);
    compare_stream("R4 R5 R6 all prefixes");

    // R5 short pulse released before press stream drains
    setup_ch(3, 8'hA0, 8'h4D);
    @(negedge clk); gpio_in[3] = 1;
    repeat (3) @(negedge clk); gpio_in[3] = 0;
    add_press(8'hA0, 8'h4D); add_release(8'hA0, 8'h4D);
    compare_stream("R5 short pulse");

    // random configurations, no ticks
    for (int it = 0; it < 16; it++) begin
      int ch;
      logic [7:0] c, mk;
      ch = int'($urandom % 4);
      c  = 8'($urandom);
      mk = 8'($urandom);
      setup_ch(ch, c, mk);
      @(negedge clk); gpio_in[ch] = 1;
      wait_bytes(press_len(c)); repeat (4) @(negedge clk);
      gpio_in[ch] = 0;
      add_press(c, mk); add_release(c, mk);
      compare_stream("R4 R5 R6 random");
    end

    // R7 R8 typematic timing
    typematic_case(1, 8'h86, 8'h33);
    typematic_case(2, 8'h3C, 8'h5A);
    typematic_case(0, 8'h53, 8'h29);

    // R9 simultaneous events: lowest first
    setup_ch(1, 8'h00, 8'h16);
    setup_ch(3, 8'h10, 8'h1E);
    @(negedge clk); gpio_in[1] = 1; gpio_in[3] = 1;
    repeat (10) @(negedge clk); gpio_in[1] = 0; gpio_in[3] = 0;
    add_press(8'h00, 8'h16); add_release(8'h00, 8'h16);
    add_press(8'h10, 8'h1E); add_release(8'h10, 8'h1E);
    compare_stream("R9 lowest first");

    // R9 event during another channel's hold waits for its release
    setup_ch(0, 8'h40, 8'h21);
    setup_ch(2, 8'h00, 8'h24);
    @(negedge clk); gpio_in[0] = 1;
    wait_bytes(2); repeat (5) @(negedge clk);
    gpio_in[2] = 1; repeat (10) @(negedge clk); gpio_in[2] = 0;
    repeat (20) @(negedge clk);
    chk(got.size() == 2, "R9", "pending waits while busy", got.size(), 2);
    gpio_in[0] = 0;
    add_press(8'h40, 8'h21); add_release(8'h40, 8'h21);
    add_press(8'h00, 8'h24); add_release(8'h00, 8'h24);
    compare_stream("R9 queued behind active channel");

    finish_run();
  end
endmodule